// File: doc/BRIEF.md
# Byte-Stream Block Loader

This engine copies a program image out of a byte-wide store into two word-wide memories. The image is a chain of blocks. Each block opens with an eight-byte header: a destination address and a length word. The data words follow the header directly. A pulse on `start` loads the byte read pointer from `base_addr`. From then on the engine consumes one byte per clock through a combinational read port (`rd_addr` out, `rd_data` back in the same cycle). It assembles each word least significant byte first and writes it to the program-memory port or to the data-memory port.

The top bit of the length word chooses the destination space. Program-memory words are 48 bits, made of six bytes. Data-memory words are 40 bits, made of five bytes. The lower 31 bits give the number of words in the block. A length word equal to zero ends the load. That header's address word is then presented on `ret_addr` together with a one-cycle `done` pulse, so that a processor can jump to it.

Top module: `block_loader`

## Requirements
- R1: During and after reset, `pm_we`, `dm_we` and `done` are low and `rd_addr` is zero.
- R2: A header is eight consecutive bytes. Bytes 0..3 form the 32-bit destination address and bytes 4..7 form the 32-bit length word, each least significant byte first.
- R3: When bit 31 of the length word is 1, each word is six bytes long. The bytes are placed least significant first into a 48-bit value and written on the program-memory port.
- R4: When bit 31 of the length word is 0, each word is five bytes long. The bytes are placed least significant first into a 40-bit value and written on the data-memory port.
- R5: The words of a block are written to consecutive addresses, beginning at the header's address, one write per word.
- R6: A `start` pulse while the engine is idle loads the read pointer with `base_addr`. The pointer then advances by one on every clock while loading, so each header follows directly after the last data byte of the block before it.
- R7: A length word of zero stops the load. `done` is high for exactly one cycle, and `ret_addr` holds that header's address. `done` rises on the clock edge that follows the cycle in which the header's last byte is read, at which point `rd_addr` equals `base_addr` plus the number of image bytes.
- R8: A write strobe lasts one cycle, with its address and data valid in that same cycle. It comes one clock after the word's final byte is read, and the two ports are never strobed together.
- R9: A non-zero length word whose lower 31 bits are zero (an empty block) causes no write. The next header is read from the byte that directly follows.
- R10: A `start` pulse while a load is in progress has no effect on the read pointer, the writes or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| base_addr | input | RD_AW | Byte address of the first header |
| rd_addr | output | RD_AW | Byte read address |
| rd_data | input | 8 | Byte at `rd_addr`, valid in the same cycle |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | ADDR_W | Program-memory write address |
| pm_wdata | output | 48 | Program-memory write data |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | ADDR_W | Data-memory write address |
| dm_wdata | output | 40 | Data-memory write data |
| done | output | 1 | One-cycle end-of-load pulse |
| ret_addr | output | 32 | Address from the terminating header |

## Verification
The first header byte is read on the clock after `start` is seen, and one more byte is read on every clock after that. Counted in falling edges from the one where `start` is first seen, `done` is therefore due exactly N edges later for an image of N bytes. A write is due on the falling edge that follows the clock reading a word's last byte. The bench samples every output on falling edges. It compares each strobe, in order, against a queue that the image builder filled, and it checks the `done` edge count and the final `rd_addr` against the byte total the builder counted.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_HDR  = 2'd1,
    LB_DATA = 2'd2
  } lb_state_e;

  localparam int unsigned LB_HDR_BYTES = 8;
  localparam int unsigned LB_PM_BYTES  = 6;
  localparam int unsigned LB_DM_BYTES  = 5;
  localparam int unsigned LB_PM_W      = LB_PM_BYTES * 8;
  localparam int unsigned LB_DM_W      = LB_DM_BYTES * 8;

  // index of the final byte of a word in the chosen space
  function automatic logic [2:0] last_byte_idx(input logic to_pm);
    return to_pm ? 3'(LB_PM_BYTES - 1) : 3'(LB_DM_BYTES - 1);
  endfunction

  // length word: all-zero means terminate
  function automatic logic is_terminator(input logic [31:0] len_word);
    return (len_word == 32'd0);
  endfunction

  // word count carried by the length word
  function automatic logic [30:0] word_count(input logic [31:0] len_word);
    return len_word[30:0];
  endfunction

endpackage

// File: rtl/lb_byte_ptr.sv
module lb_byte_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (step) begin
      ptr <= ptr + AW'(1);
    end
  end

endmodule

// File: rtl/lb_assembler.sv
module lb_assembler #(
  parameter int unsigned NB = 8,
  localparam int unsigned W = NB * 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [2:0]   idx,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] word_now
);

  logic [W-1:0] held;

  // lane g takes the new byte when idx selects it; a word that starts at
  // idx 0 clears the older lanes so stale upper bytes never leak through
  for (genvar g = 0; g < int'(NB); g++) begin : g_lane
    always_comb begin
      if (idx == 3'(g)) begin
        word_now[g*8 +: 8] = byte_in;
      end else if (idx == 3'd0) begin
        word_now[g*8 +: 8] = 8'h00;
      end else begin
        word_now[g*8 +: 8] = held[g*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (take) begin
      held <= word_now;
    end
  end

endmodule

// File: rtl/block_loader.sv
module block_loader
  import lb_pkg::*;
#(
  parameter int unsigned RD_AW  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RD_AW-1:0]  base_addr,
  output logic [RD_AW-1:0]  rd_addr,
  input  logic [7:0]        rd_data,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [47:0]       pm_wdata,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [39:0]       dm_wdata,
  output logic              done,
  output logic [31:0]       ret_addr
);

  localparam int unsigned HDR_W = LB_HDR_BYTES * 8;

  lb_state_e         state;
  logic [2:0]        byte_idx;
  logic [30:0]       words_left;
  logic [ADDR_W-1:0] dest;
  logic              to_pm;

  logic [HDR_W-1:0]   hdr_now;
  logic [LB_PM_W-1:0] word_now;
  logic [31:0]        hdr_dst;
  logic [31:0]        hdr_len;

  // named events, also observed by the checker
  logic accept_ev;
  logic consume;
  logic hdr_last_ev;
  logic term_ev;
  logic empty_ev;
  logic word_last_ev;

  assign accept_ev    = (state == LB_IDLE) && start;
  assign consume      = (state != LB_IDLE);
  assign hdr_dst      = hdr_now[31:0];
  assign hdr_len      = hdr_now[63:32];
  assign hdr_last_ev  = (state == LB_HDR) && (byte_idx == 3'(LB_HDR_BYTES - 1));
  assign term_ev      = hdr_last_ev && is_terminator(hdr_len);
  assign empty_ev     = hdr_last_ev && !is_terminator(hdr_len)
                        && (word_count(hdr_len) == 31'd0);
  assign word_last_ev = (state == LB_DATA) && (byte_idx == last_byte_idx(to_pm));

  lb_byte_ptr #(.AW(RD_AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_ev),
    .load_val (base_addr),
    .step     (consume),
    .ptr      (rd_addr)
  );

  lb_assembler #(.NB(LB_HDR_BYTES)) u_hdr_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (state == LB_HDR),
    .idx      (byte_idx),
    .byte_in  (rd_data),
    .word_now (hdr_now)
  );

  lb_assembler #(.NB(LB_PM_BYTES)) u_word_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (state == LB_DATA),
    .idx      (byte_idx),
    .byte_in  (rd_data),
    .word_now (word_now)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LB_IDLE;
      byte_idx   <= '0;
      words_left <= '0;
      dest       <= '0;
      to_pm      <= 1'b0;
    end else begin
      unique case (state)
        LB_IDLE: begin
          if (start) begin
            state    <= LB_HDR;
            byte_idx <= '0;
          end
        end
        LB_HDR: begin
          if (hdr_last_ev) begin
            byte_idx <= '0;
            if (term_ev) begin
              state <= LB_IDLE;
            end else if (!empty_ev) begin
              state      <= LB_DATA;
              words_left <= word_count(hdr_len);
              dest       <= hdr_dst[ADDR_W-1:0];
              to_pm      <= hdr_len[31];
            end
          end else begin
            byte_idx <= byte_idx + 3'd1;
          end
        end
        LB_DATA: begin
          if (word_last_ev) begin
            byte_idx   <= '0;
            dest       <= dest + ADDR_W'(1);
            words_left <= words_left - 31'd1;
            if (words_left == 31'd1) begin
              state <= LB_HDR;
            end
          end else begin
            byte_idx <= byte_idx + 3'd1;
          end
        end
        default: state <= LB_IDLE;
      endcase
    end
  end

  // registered write ports and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
      dm_we    <= 1'b0;
      dm_addr  <= '0;
      dm_wdata <= '0;
      done     <= 1'b0;
      ret_addr <= '0;
    end else begin
      pm_we <= word_last_ev && to_pm;
      dm_we <= word_last_ev && !to_pm;
      done  <= term_ev;
      if (word_last_ev && to_pm) begin
        pm_addr  <= dest;
        pm_wdata <= word_now;
      end
      if (word_last_ev && !to_pm) begin
        dm_addr  <= dest;
        dm_wdata <= word_now[LB_DM_W-1:0];
      end
      if (term_ev) begin
        ret_addr <= hdr_dst;
      end
    end
  end

endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int unsigned RD_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [RD_AW-1:0] rd_addr,
  input logic             pm_we,
  input logic             dm_we,
  input logic             done,
  input logic             consume,
  input logic             term_ev,
  input logic             word_last_ev
);

  p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_we && dm_we));

  p_we_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we || dm_we) |-> $past(word_last_ev));

  p_pm_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !pm_we);

  p_dm_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> !dm_we);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(term_ev));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (rd_addr == $past(rd_addr) + 1'b1));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && start) |=> (rd_addr == $past(rd_addr) + 1'b1));

  p_no_write_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !$past(consume)) |-> !(pm_we || dm_we));

endmodule

bind block_loader lb_checker #(.RD_AW(RD_AW)) u_lb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rd_addr      (rd_addr),
  .pm_we        (pm_we),
  .dm_we        (dm_we),
  .done         (done),
  .consume      (consume),
  .term_ev      (term_ev),
  .word_last_ev (word_last_ev)
);

// File: tb/test_block_loader.sv
`timescale 1ns/1ps
module test_block_loader;

  localparam int unsigned RD_AW  = 16;
  localparam int unsigned ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [RD_AW-1:0]  base_addr = '0;
  logic [RD_AW-1:0]  rd_addr;
  logic [7:0]        rd_data;
  logic              pm_we, dm_we, done;
  logic [ADDR_W-1:0] pm_addr, dm_addr;
  logic [47:0]       pm_wdata;
  logic [39:0]       dm_wdata;
  logic [31:0]       ret_addr;

  always #2 clk = ~clk;

  logic [7:0] mem [256];
  assign rd_data = mem[rd_addr[7:0]];

  block_loader #(.RD_AW(RD_AW), .ADDR_W(ADDR_W)) i_block_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .done(done), .ret_addr(ret_addr)
  );

  typedef struct packed {
    logic        pm;
    logic [31:0] a;
    logic [47:0] d;
  } exp_wr_t;

  exp_wr_t exp_q [$];
  int checks = 0;
  int fails  = 0;
  int wp     = 0;
  int nbytes = 0;
  int exp_n  = 0;
  int ncyc   = 0;
  int s_cyc  = 0;
  int done_cnt = 0;
  bit running = 1'b0;
  logic [31:0]      exp_ret = '0;
  logic [RD_AW-1:0] exp_end = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- image builder (driver side) ----------------
  task automatic put_byte(input logic [7:0] b);
    mem[wp[7:0]] = b;
    wp++;
    nbytes++;
  endtask

  task automatic put_hdr(input logic [31:0] a, input logic [31:0] lw);
    for (int i = 0; i < 4; i++) put_byte(a[i*8 +: 8]);
    for (int i = 0; i < 4; i++) put_byte(lw[i*8 +: 8]);
  endtask

  function automatic logic [47:0] mkval(input int k);
    return {8'(k + 8'h11), 8'(k * 3), 8'(8'hA5 ^ k),
            8'(k + 8'h40), 8'(8'h5A + k), 8'(k * 5 + 1)};
  endfunction

  task automatic put_block(input bit pm, input logic [31:0] a,
                           input int cnt, input int seed);
    put_hdr(a, {pm, 31'(cnt)});
    for (int k = 0; k < cnt; k++) begin
      logic [47:0] v;
      exp_wr_t e;
      v = mkval(seed + k);
      if (!pm) v[47:40] = 8'h00;
      for (int i = 0; i < (pm ? 6 : 5); i++) put_byte(v[i*8 +: 8]);
      e.pm = pm;
      e.a  = a + 32'(k);
      e.d  = v;
      exp_q.push_back(e);
    end
  endtask

  task automatic begin_image(input int base);
    wp = base;
    nbytes = 0;
  endtask

  task automatic run_image(input logic [RD_AW-1:0] base,
                           input logic [31:0] ret, input bit poke);
    int target;
    exp_ret = ret;
    exp_n   = nbytes;
    exp_end = base + RD_AW'(nbytes);
    target  = done_cnt + 1;
    @(negedge clk);
    start     <= 1'b1;
    base_addr <= base;
    @(negedge clk);
    start <= 1'b0;
    if (poke) begin
      // R10: a second start during the load must change nothing
      repeat (10) @(negedge clk);
      start     <= 1'b1;
      base_addr <= 16'h00F0;
      @(negedge clk);
      start     <= 1'b0;
      base_addr <= base;
    end
    wait (done_cnt == target);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5", "writes left unseen", 64'(exp_q.size()), 64'd0);
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (!running && start) begin
        running = 1'b1;
        s_cyc   = ncyc;
      end
      if (pm_we && dm_we)
        chk(1'b0, "R8", "both write strobes high", 64'd3, 64'd1);
      if (pm_we || dm_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected write", {31'd0, pm_we, pm_addr}, 64'd0);
        end else begin
          exp_wr_t e;
          e = exp_q.pop_front();
          if (e.pm) begin
            chk(pm_we, "R3", "program port used", 64'(pm_we), 64'd1);
            chk(pm_wdata == e.d, "R3", "program word data", 64'(pm_wdata), 64'(e.d));
            chk(pm_addr == e.a, "R5", "program word address", 64'(pm_addr), 64'(e.a));
          end else begin
            chk(dm_we, "R4", "data port used", 64'(dm_we), 64'd1);
            chk(dm_wdata == e.d[39:0], "R4", "data word data", 64'(dm_wdata), 64'(e.d[39:0]));
            chk(dm_addr == e.a, "R5", "data word address", 64'(dm_addr), 64'(e.a));
          end
        end
      end
      if (done) begin
        chk(ret_addr == exp_ret, "R7", "return address", 64'(ret_addr), 64'(exp_ret));
        chk((ncyc - s_cyc) == exp_n, "R7", "done timing (edges)",
            64'(ncyc - s_cyc), 64'(exp_n));
        chk(rd_addr == exp_end, "R6", "read pointer at end", 64'(rd_addr), 64'(exp_end));
        running = 1'b0;
        done_cnt++;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin : wd
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pm_we == 1'b0, "R1", "pm_we in reset", 64'(pm_we), 64'd0);
    chk(dm_we == 1'b0, "R1", "dm_we in reset", 64'(dm_we), 64'd0);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    chk(rd_addr == '0, "R1", "rd_addr in reset", 64'(rd_addr), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);

    // R2 R3 R4 R5 R6 R10: program block, data block, terminator; busy start
    begin_image(16'h10);
    put_block(1'b1, 32'h0000_0100, 2, 1);
    put_block(1'b0, 32'h0000_2000, 3, 9);
    put_hdr(32'h0001_FF00, 32'h0);
    run_image(16'h0010, 32'h0001_FF00, 1'b1);

    // R9: empty block, then a data block whose address wraps
    begin_image(16'h60);
    put_hdr(32'h0000_0777, 32'h8000_0000);
    put_block(1'b0, 32'hFFFF_FFFF, 2, 20);
    put_block(1'b1, 32'h0000_0040, 1, 30);
    put_hdr(32'hDEAD_BEEF, 32'h0);
    run_image(16'h0060, 32'hDEAD_BEEF, 1'b0);

    // R7: terminator straight away, no writes
    begin_image(16'hC0);
    put_hdr(32'h1234_5678, 32'h0);
    run_image(16'h00C0, 32'h1234_5678, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done is a single pulse", 64'(done), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule